// File: doc/BRIEF.md
# Severity-Grouped Error Collector

This block gathers error events from a set of on-chip diagnostic sources and turns each event into a response chosen by the severity group of its source. Three responses exist: a maskable interrupt, a non-maskable interrupt and an active-low error pin that shows an outside observer the device has entered a faulty state. The sources are wired onto one input vector. The lowest `G1_N` bits form group 1, the next `G2_N` bits form group 2, and the top `G3_N` bits form group 3.

Group 1 is the mild group. Software chooses, per source, whether it raises the interrupt and whether it drives the pin. Group 2 always raises the non-maskable interrupt and drives the pin. Group 3 only drives the pin. Each source has its own status bit, which is set by a rising edge of the source and cleared by writing one to it.

A warm reset leaves the critical status (groups 2 and 3) and the pin state intact, so that software can diagnose the fault after the reset. A power-on reset clears everything. Once the pin has gone low, it stays low for a programmable minimum number of cycles. Only after that can a software release take it high again.

Top module: `errSeverityHub`

## Requirements
- R1: After a power-on reset, `irqOut` and `nmiOut` are 0, `errPinN` is 1, and every status register reads 0.
- R2: A status bit is set on a rising edge of its source input. A source that stays high does not set its bit again after that bit has been cleared.
- R3: Writing to a status register clears each bit written as 1 and leaves each bit written as 0. The status registers are: address 2 for group 1, address 3 for group 2 and address 4 for group 3.
- R4: `irqOut` is 1 while any group 1 status bit is set whose interrupt-enable bit is also set. The interrupt-enable register is at address 0.
- R5: A rising edge on a group 1 source whose pin-enable bit is set drives `errPinN` low at that clock edge. The pin-enable register is at address 1. A rising edge on a source whose pin-enable bit is clear leaves the pin high.
- R6: `nmiOut` is 1 while any group 2 status bit is set. A group 2 rising edge also drives `errPinN` low.
- R7: A group 3 rising edge drives `errPinN` low and raises neither `irqOut` nor `nmiOut`.
- R8: When the pin is driven low, a down-counter is loaded with the minimum-low value held at address 5. Writing 1 to bit 0 of address 6 releases the pin only once that counter has reached 0, and such writes are ignored before then. With a minimum of M, the pin is low for M+1 edges before a release can take effect. Bit 0 of address 6 reads 1 while the pin is low.
- R9: A rising edge that arrives in the same cycle as a write-one-to-clear of its own bit wins, and the bit stays set.
- R10: A warm reset clears the group 1 status bits and both enable registers, and returns the minimum-low register to `PIN_MIN_DEF`. It keeps the group 2 and group 3 status bits and the pin state. A power-on reset clears all of these.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| porRstN | input | 1 | Power-on reset, active low, asynchronous |
| warmRstN | input | 1 | Warm reset, active low, asynchronous |
| errIn | input | G1_N+G2_N+G3_N | Error sources, group 1 in the low bits, group 3 in the high bits |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | ADDR_W | Register address |
| regWrData | input | DATA_W | Register write data |
| regRdData | output | DATA_W | Register read data, combinational from `regAddr` |
| irqOut | output | 1 | Maskable interrupt request |
| nmiOut | output | 1 | Non-maskable interrupt request |
| errPinN | output | 1 | Error pin, low while the device is faulty |

## Verification
The bench builds the block with its default parameters: eight group 1 sources, four group 2 sources, four group 3 sources and an 8-bit minimum-low counter. With these values, every group and a mixed enable pattern fit in one short vector table. The minimum-low value is reprogrammed to 0 for the table, so each vector can release the pin at once. It is then set to 3, so that the edge on which a release first takes effect can be pinned down exactly. Directed cases cover a source held high across a clear, a rising edge that collides with its own clear, and a warm reset followed by a power-on reset.

// File: rtl/errsev_pkg.sv
package errsev_pkg;
  localparam int ADR_IRQ_EN  = 0;
  localparam int ADR_PIN_EN  = 1;
  localparam int ADR_STAT_G1 = 2;
  localparam int ADR_STAT_G2 = 3;
  localparam int ADR_STAT_G3 = 4;
  localparam int ADR_MIN_LOW = 5;
  localparam int ADR_PIN_CTL = 6;

  typedef struct packed {
    logic wrIrqEn;
    logic wrPinEn;
    logic clrG1;
    logic clrG2;
    logic clrG3;
    logic wrMinLow;
    logic relReq;
  } errsevStrb_t;
endpackage

// File: rtl/errsevDatapath.sv
module errsevDatapath
  import errsev_pkg::*;
#(
  parameter int G1_N   = 8,
  parameter int G2_N   = 4,
  parameter int G3_N   = 4,
  parameter int DATA_W = 16
) (
  input  logic                          clk,
  input  logic                          porRstN,
  input  logic                          warmRstN,
  input  logic [G1_N+G2_N+G3_N-1:0]     errIn,
  input  errsevStrb_t                   strb,
  input  logic [DATA_W-1:0]             wrData,
  output logic [G1_N-1:0]               statG1,
  output logic [G2_N-1:0]               statG2,
  output logic [G3_N-1:0]               statG3,
  output logic [G1_N-1:0]               irqEnQ,
  output logic [G1_N-1:0]               pinEnQ,
  output logic                          irqOut,
  output logic                          nmiOut,
  output logic                          pinTrig
);
  localparam int NUM_SRC = G1_N + G2_N + G3_N;
  localparam int G2_LO   = G1_N;
  localparam int G3_LO   = G1_N + G2_N;

  logic anyRstN;
  assign anyRstN = porRstN & warmRstN;

  logic [NUM_SRC-1:0] errPrev, riseAll, clrAll, statAll;
  logic [G1_N-1:0] riseG1, clrG1;
  logic [G2_N-1:0] riseG2, clrG2;
  logic [G3_N-1:0] riseG3, clrG3;

  assign riseAll = errIn & ~errPrev;
  assign riseG1  = riseAll[G1_N-1:0];
  assign riseG2  = riseAll[G3_LO-1:G2_LO];
  assign riseG3  = riseAll[NUM_SRC-1:G3_LO];

  assign clrG1 = strb.clrG1 ? wrData[G1_N-1:0] : '0;
  assign clrG2 = strb.clrG2 ? wrData[G2_N-1:0] : '0;
  assign clrG3 = strb.clrG3 ? wrData[G3_N-1:0] : '0;
  assign clrAll  = {clrG3, clrG2, clrG1};
  assign statAll = {statG3, statG2, statG1};

  always_ff @(posedge clk or negedge anyRstN) begin
    if (!anyRstN) begin
      errPrev <= '0;
      statG1  <= '0;
      irqEnQ  <= '0;
      pinEnQ  <= '0;
    end else begin
      errPrev <= errIn;
      statG1  <= (statG1 & ~clrG1) | riseG1;
      if (strb.wrIrqEn) irqEnQ <= wrData[G1_N-1:0];
      if (strb.wrPinEn) pinEnQ <= wrData[G1_N-1:0];
    end
  end

  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN) begin
      statG2 <= '0;
      statG3 <= '0;
    end else begin
      statG2 <= (statG2 & ~clrG2) | riseG2;
      statG3 <= (statG3 & ~clrG3) | riseG3;
    end
  end

  assign irqOut  = |(statG1 & irqEnQ);
  assign nmiOut  = |statG2;
  assign pinTrig = (|(riseG1 & pinEnQ)) | (|riseG2) | (|riseG3);

  // R2
  status_edge_chk: assert property (@(posedge clk) disable iff (!anyRstN)
    1'b1 |=> ((statAll & ~$past(statAll) & ~$past(riseAll)) == '0));
  // R3
  clr_w1c_chk: assert property (@(posedge clk) disable iff (!anyRstN)
    ((clrAll & ~riseAll) != '0) |=> ((statAll & $past(clrAll & ~riseAll)) == '0));
  // R9
  clr_priority_chk: assert property (@(posedge clk) disable iff (!anyRstN)
    ((riseAll & clrAll) != '0) |=>
      ((statAll & $past(riseAll & clrAll)) == $past(riseAll & clrAll)));
endmodule

// File: rtl/errsevCtrl.sv
module errsevCtrl
  import errsev_pkg::*;
#(
  parameter int ADDR_W      = 3,
  parameter int DATA_W      = 16,
  parameter int CNT_W       = 8,
  parameter int PIN_MIN_DEF = 4
) (
  input  logic              clk,
  input  logic              porRstN,
  input  logic              warmRstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  input  logic              pinTrig,
  output errsevStrb_t       strb,
  output logic [CNT_W-1:0]  minLowQ,
  output logic              pinActive
);
  logic anyRstN;
  assign anyRstN = porRstN & warmRstN;

  logic [CNT_W-1:0] holdCnt;

  always_comb begin
    strb          = '0;
    strb.wrIrqEn  = regWrEn && (regAddr == ADDR_W'(ADR_IRQ_EN));
    strb.wrPinEn  = regWrEn && (regAddr == ADDR_W'(ADR_PIN_EN));
    strb.clrG1    = regWrEn && (regAddr == ADDR_W'(ADR_STAT_G1));
    strb.clrG2    = regWrEn && (regAddr == ADDR_W'(ADR_STAT_G2));
    strb.clrG3    = regWrEn && (regAddr == ADDR_W'(ADR_STAT_G3));
    strb.wrMinLow = regWrEn && (regAddr == ADDR_W'(ADR_MIN_LOW));
    strb.relReq   = regWrEn && (regAddr == ADDR_W'(ADR_PIN_CTL)) && regWrData[0];
  end

  always_ff @(posedge clk or negedge anyRstN) begin
    if (!anyRstN) minLowQ <= CNT_W'(PIN_MIN_DEF);
    else if (strb.wrMinLow) minLowQ <= regWrData[CNT_W-1:0];
  end

  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN) begin
      pinActive <= 1'b0;
      holdCnt   <= '0;
    end else if (pinTrig) begin
      pinActive <= 1'b1;
      holdCnt   <= minLowQ;
    end else if (strb.relReq && pinActive && (holdCnt == '0)) begin
      pinActive <= 1'b0;
    end else if (holdCnt != '0) begin
      holdCnt <= holdCnt - 1'b1;
    end
  end

  // R5
  pin_set_chk: assert property (@(posedge clk) disable iff (!porRstN)
    pinTrig |=> pinActive);
  // R8
  minlow_hold_chk: assert property (@(posedge clk) disable iff (!porRstN)
    (pinActive && (holdCnt != '0)) |=> pinActive);
endmodule

// File: rtl/errSeverityHub.sv
module errSeverityHub
  import errsev_pkg::*;
#(
  parameter int G1_N        = 8,
  parameter int G2_N        = 4,
  parameter int G3_N        = 4,
  parameter int ADDR_W      = 3,
  parameter int DATA_W      = 16,
  parameter int CNT_W       = 8,
  parameter int PIN_MIN_DEF = 4
) (
  input  logic                      clk,
  input  logic                      porRstN,
  input  logic                      warmRstN,
  input  logic [G1_N+G2_N+G3_N-1:0] errIn,
  input  logic                      regWrEn,
  input  logic [ADDR_W-1:0]         regAddr,
  input  logic [DATA_W-1:0]         regWrData,
  output logic [DATA_W-1:0]         regRdData,
  output logic                      irqOut,
  output logic                      nmiOut,
  output logic                      errPinN
);
  errsevStrb_t      strb;
  logic [G1_N-1:0]  statG1, irqEnQ, pinEnQ;
  logic [G2_N-1:0]  statG2;
  logic [G3_N-1:0]  statG3;
  logic [CNT_W-1:0] minLowQ;
  logic             pinTrig, pinActive;

  errsevCtrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W),
               .PIN_MIN_DEF(PIN_MIN_DEF)) ctrl_i (
    .clk(clk), .porRstN(porRstN), .warmRstN(warmRstN),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .pinTrig(pinTrig), .strb(strb), .minLowQ(minLowQ), .pinActive(pinActive));

  errsevDatapath #(.G1_N(G1_N), .G2_N(G2_N), .G3_N(G3_N), .DATA_W(DATA_W)) dp_i (
    .clk(clk), .porRstN(porRstN), .warmRstN(warmRstN), .errIn(errIn),
    .strb(strb), .wrData(regWrData), .statG1(statG1), .statG2(statG2),
    .statG3(statG3), .irqEnQ(irqEnQ), .pinEnQ(pinEnQ), .irqOut(irqOut),
    .nmiOut(nmiOut), .pinTrig(pinTrig));

  assign errPinN = ~pinActive;

  always_comb begin
    regRdData = '0;
    case (regAddr)
      ADDR_W'(ADR_IRQ_EN):  regRdData[G1_N-1:0]  = irqEnQ;
      ADDR_W'(ADR_PIN_EN):  regRdData[G1_N-1:0]  = pinEnQ;
      ADDR_W'(ADR_STAT_G1): regRdData[G1_N-1:0]  = statG1;
      ADDR_W'(ADR_STAT_G2): regRdData[G2_N-1:0]  = statG2;
      ADDR_W'(ADR_STAT_G3): regRdData[G3_N-1:0]  = statG3;
      ADDR_W'(ADR_MIN_LOW): regRdData[CNT_W-1:0] = minLowQ;
      ADDR_W'(ADR_PIN_CTL): regRdData[0]         = pinActive;
      default:              regRdData = '0;
    endcase
  end
endmodule

// File: tb/errSeverityHub_tb_top.sv
module errSeverityHub_tb_top;
  logic        clk = 1'b0;
  logic        porRstN = 1'b0, warmRstN = 1'b1;
  logic [15:0] errIn = '0;
  logic        regWrEn = 1'b0;
  logic [2:0]  regAddr = '0;
  logic [15:0] regWrData = '0;
  logic [15:0] regRdData;
  logic        irqOut, nmiOut, errPinN;
  int          nChk = 0, nFail = 0;

  always #5 clk = ~clk;

  errSeverityHub dut_i (.clk(clk), .porRstN(porRstN), .warmRstN(warmRstN),
    .errIn(errIn), .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData), .irqOut(irqOut), .nmiOut(nmiOut), .errPinN(errPinN));

  // vector: g1[18:11] g2[10:7] g3[6:3] expIrq[2] expNmi[1] expPinLow[0]
  // setup: irq enable = 0x0F, pin enable = 0xF0
  localparam logic [18:0] VEC [8] = '{
    {8'h01, 4'h0, 4'h0, 3'b100},
    {8'h10, 4'h0, 4'h0, 3'b001},
    {8'h11, 4'h0, 4'h0, 3'b101},
    {8'h00, 4'h1, 4'h0, 3'b011},
    {8'h00, 4'h0, 4'h1, 3'b001},
    {8'h00, 4'h0, 4'h0, 3'b000},
    {8'h02, 4'h0, 4'h8, 3'b101},
    {8'h00, 4'h8, 4'h0, 3'b011}};

  task automatic step();
    @(posedge clk); #2;
  endtask

  task automatic chk(string tag, logic [15:0] got, logic [15:0] exp);
    nChk++;
    if (got !== exp) begin
      nFail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [15:0] d);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    step();
    regWrEn = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [15:0] d);
    regAddr = a; #1; d = regRdData;
  endtask

  task automatic cleanAll();
    wr(3'd2, 16'hFFFF); wr(3'd3, 16'hFFFF); wr(3'd4, 16'hFFFF); wr(3'd6, 16'h0001);
  endtask

  initial begin
    #200000;
    nChk++; nFail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

  initial begin
    logic [15:0] d;
    step(); step(); porRstN = 1'b1; step();
    // R1 reset state
    chk("R1 irq", {15'd0, irqOut}, 16'd0);
    chk("R1 nmi", {15'd0, nmiOut}, 16'd0);
    chk("R1 pin", {15'd0, errPinN}, 16'd1);
    for (int a = 2; a <= 4; a++) begin rd(3'(a), d); chk("R1 status", d, 16'd0); end

    wr(3'd0, 16'h000F); wr(3'd1, 16'h00F0); wr(3'd5, 16'h0000);
    // R4 R5 R6 R7 table walk
    for (int i = 0; i < 8; i++) begin
      errIn = {VEC[i][6:3], VEC[i][10:7], VEC[i][18:11]};
      step();
      errIn = '0;
      chk("R4 irq", {15'd0, irqOut}, {15'd0, VEC[i][2]});
      chk("R6 nmi", {15'd0, nmiOut}, {15'd0, VEC[i][1]});
      chk("R5 R7 pin", {15'd0, ~errPinN}, {15'd0, VEC[i][0]});
      rd(3'd2, d); chk("R2 g1 status", d, {8'd0, VEC[i][18:11]});
      rd(3'd3, d); chk("R2 g2 status", d, {12'd0, VEC[i][10:7]});
      rd(3'd4, d); chk("R2 g3 status", d, {12'd0, VEC[i][6:3]});
      cleanAll();
      chk("R3 cleared irq", {15'd0, irqOut}, 16'd0);
      chk("R8 released", {15'd0, errPinN}, 16'd1);
    end

    // R3 partial clear
    errIn = 16'h0005; step(); errIn = '0;
    wr(3'd2, 16'h0001);
    rd(3'd2, d); chk("R3 partial", d, 16'h0004);
    cleanAll();

    // R2 held source does not re-set
    errIn = 16'h0004; step();
    wr(3'd2, 16'h0004); step();
    rd(3'd2, d); chk("R2 held high", d, 16'h0000);
    errIn = '0; step();

    // R9 rise collides with clear
    errIn = 16'h0001; step(); errIn = '0; step();
    errIn = 16'h0002; regWrEn = 1'b1; regAddr = 3'd2; regWrData = 16'h0003;
    step(); regWrEn = 1'b0; errIn = '0;
    rd(3'd2, d); chk("R9 priority", d, 16'h0002);
    cleanAll();

    // R8 minimum low with M=3
    wr(3'd5, 16'd3);
    errIn = 16'h1000; step(); errIn = '0;
    regWrEn = 1'b1; regAddr = 3'd6; regWrData = 16'h0001;
    step(); chk("R8 hold e1", {15'd0, errPinN}, 16'd0);
    rd(3'd6, d); chk("R8 pin readback", d, 16'd1);
    step(); chk("R8 hold e2", {15'd0, errPinN}, 16'd0);
    step(); chk("R8 hold e3", {15'd0, errPinN}, 16'd0);
    step(); chk("R8 release e4", {15'd0, errPinN}, 16'd1);
    regWrEn = 1'b0;
    cleanAll();

    // R10 warm reset keeps critical state
    wr(3'd0, 16'h0001);
    errIn = 16'h0101; step(); errIn = '0;
    warmRstN = 1'b0; step(); warmRstN = 1'b1; step();
    rd(3'd2, d); chk("R10 g1 cleared", d, 16'd0);
    rd(3'd0, d); chk("R10 irqEn cleared", d, 16'd0);
    rd(3'd3, d); chk("R10 g2 kept", d, 16'h0001);
    rd(3'd5, d); chk("R10 minLow default", d, 16'd4);
    chk("R10 nmi kept", {15'd0, nmiOut}, 16'd1);
    chk("R10 pin kept", {15'd0, errPinN}, 16'd0);
    porRstN = 1'b0; step(); porRstN = 1'b1; step();
    rd(3'd3, d); chk("R10 por g2", d, 16'd0);
    chk("R10 por pin", {15'd0, errPinN}, 16'd1);
    chk("R10 por nmi", {15'd0, nmiOut}, 16'd0);

    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end
endmodule